// File: doc/BRIEF.md
# Configuration Access Router with Bridge Bus Numbering

This block sits between a single upstream source of configuration accesses and a set of function slots. Each access carries a 24-bit address, a length of 1, 2 or 4 bytes and, for writes, 32 bits of data. The block splits the address into a bus number, a device/function code and a register offset. It decides whether the bus number belongs to the local bus or to a bus that one of the bridges has claimed. It then looks for a populated slot with the matching segment and device/function code, and presents the access to that slot one cycle later.

Reads that find no slot return all ones, sized to the access length. The block also watches routed writes to each bridge's own header slot. It captures the secondary bus number written there, so that later accesses to that bus number go to the slots that sit behind the bridge. Slot placement is fixed by parameters: each slot has a device/function code and a segment, where segment 0 is the local bus and segment b+1 is the bus behind bridge b. An input mask marks which slots are populated.

The controller has three states. `ST_IDLE` means no response is due. `ST_HIT` means a routed access is presented to one slot. `ST_MISS` means an unrouted access is answered by the router itself. The state is chosen on every clock edge from the request present at that edge:
- `T_NONE` leads to `ST_IDLE` when no request is present.
- `T_ROUTE` leads to `ST_HIT` when the request found a slot.
- `T_REJECT` leads to `ST_MISS` when the request found no slot.

Any state can take any of these transitions, so requests may arrive back to back.

Top module: `cfg_router`

## Requirements
- R1: Address bits 23:16 are the bus number, bits 15:8 the device/function code (device in bits 15:11, function in bits 10:8), and bits 7:0 the register offset; the offset of a routed access appears unchanged on `slot_offset`.
- R2: A slot is selected when its present bit is set, its segment equals the segment of the bus number, and its device/function code equals address bits 15:8. If several slots match, the lowest slot index wins.
- R3: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. A routed access drives `slot_sel`, `slot_write`, `slot_offset`, `slot_len` and `slot_wdata` in that same cycle. Back-to-back requests are each answered.
- R4: A routed read returns the 32-bit `slot_rdata` word of the selected slot on `rsp_rdata`.
- R5: A read that is not routed returns 0x000000FF for length 1, 0x0000FFFF for length 2, and 0xFFFFFFFF for any other length.
- R6: A write that is not routed selects no slot and changes no secondary bus number.
- R7: A routed write at offset 0x19 to the header slot of bridge b sets that bridge's secondary bus number to data bits 7:0. The same write to a slot that is not a bridge header changes nothing.
- R8: A routed write at offset 0x18 with a length greater than 1 to the header slot of bridge b sets that bridge's secondary bus number to data bits 15:8. The same write with length 1 changes nothing.
- R9: Every secondary bus number resets to 0. A bridge whose number is 0 claims no bus.
- R10: A bus number equal to the local bus number always maps to segment 0. Otherwise it maps to segment b+1 of the lowest-indexed bridge b whose nonzero secondary number equals it.
- R11: A slot whose present bit is clear is never selected; reads to its address return all ones.
- R12: At most one `slot_sel` bit is high, and only while `rsp_valid` is high. `rsp_rdata` is 0 for every write response and in every cycle without a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 24 | Bus number, device/function code, register offset |
| req_len | input | 3 | Access length in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data or all-ones fill |
| slot_sel | output | NUM_SLOTS | One-hot select of the routed slot |
| slot_write | output | 1 | Routed access is a write |
| slot_offset | output | 8 | Register offset of the routed access |
| slot_len | output | 3 | Length of the routed access |
| slot_wdata | output | 32 | Write data of the routed access |
| slot_rdata | input | NUM_SLOTS*32 | Read word of each slot, slot i in bits 32i+31:32i |
| slot_present | input | NUM_SLOTS | Populated-slot mask |

## Verification
The bench first sends reads to local and downstream bus numbers before any bridge is numbered. This shows that a zero secondary number claims nothing. It then numbers each bridge through both header offsets and repeats the reads, which separates correct field extraction (bits 7:0 against bits 15:8) from a swapped one. Length-1 writes at offset 0x18, offset 0x19 writes to a non-bridge slot, and writes to unclaimed buses test that the numbering ignores what it must ignore. Two bridges given the same number, a cleared present bit, and miss reads at all three lengths cover the priority and fill-value corners. The reference model is compared with the outputs on every cycle, including idle cycles and back-to-back requests.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } rt_state_t;

    // Fill value for a read that found no slot (R5)
    function automatic logic [31:0] miss_fill(input logic [2:0] len);
        logic [31:0] v;
        unique case (len)
            3'd1:    v = 32'h0000_00FF;
            3'd2:    v = 32'h0000_FFFF;
            default: v = 32'hFFFF_FFFF;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfg_bus_decode.sv
// Maps a bus number to a segment: 0 = local, b+1 = behind bridge b.
module cfg_bus_decode #(
    parameter int            NUM_BRIDGES = 2,
    parameter int            SEG_W       = 2,
    parameter logic [7:0]    LOCAL_BUS   = 8'd0
) (
    input  logic [7:0]               bus_num,
    input  logic [NUM_BRIDGES*8-1:0] sec_flat,
    output logic                     claimed,
    output logic [SEG_W-1:0]         seg
);

    logic local_hit;

    assign local_hit = (bus_num == LOCAL_BUS);

    always_comb begin
        claimed = local_hit;
        seg     = '0;
        // descending scan: the lowest matching bridge is assigned last
        for (int b = NUM_BRIDGES - 1; b >= 0; b--) begin
            if (!local_hit && (sec_flat[b*8 +: 8] != 8'd0) &&
                (sec_flat[b*8 +: 8] == bus_num)) begin
                claimed = 1'b1;
                seg     = SEG_W'(b + 1);
            end
        end
    end

endmodule

// File: rtl/cfg_slot_match.sv
// Compares the routed segment and device/function code against every slot.
module cfg_slot_match #(
    parameter int                        NUM_SLOTS  = 6,
    parameter int                        SEG_W      = 2,
    parameter int                        IDX_W      = 3,
    parameter logic [NUM_SLOTS*8-1:0]    SLOT_DEVFN = '0,
    parameter logic [NUM_SLOTS*4-1:0]    SLOT_SEG   = '0
) (
    input  logic                 claimed,
    input  logic [SEG_W-1:0]     seg,
    input  logic [7:0]           devfn,
    input  logic [NUM_SLOTS-1:0] present,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);

    logic [NUM_SLOTS-1:0] match;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign match[i] = claimed && present[i] &&
                          (SLOT_SEG[i*4 +: 4] == 4'(seg)) &&
                          (SLOT_DEVFN[i*8 +: 8] == devfn);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cfg_bridge_regs.sv
// Secondary bus number of each bridge, learned from routed header writes.
module cfg_bridge_regs #(
    parameter int                         NUM_BRIDGES = 2,
    parameter int                         IDX_W       = 3,
    parameter logic [NUM_BRIDGES*4-1:0]   BRIDGE_SLOT = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [7:0]               wr_offset,
    input  logic [2:0]               wr_len,
    input  logic [15:0]              wr_data,
    output logic [NUM_BRIDGES*8-1:0] sec_flat
);

    localparam logic [7:0] OFF_SEC_LO = 8'h18;
    localparam logic [7:0] OFF_SEC_HI = 8'h19;

    for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
        logic own_slot;
        assign own_slot = wr_en && (wr_idx == IDX_W'(BRIDGE_SLOT[b*4 +: 4]));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sec_flat[b*8 +: 8] <= 8'd0;
            end else if (own_slot && wr_offset == OFF_SEC_HI) begin
                sec_flat[b*8 +: 8] <= wr_data[7:0];
            end else if (own_slot && wr_offset == OFF_SEC_LO && wr_len > 3'd1) begin
                sec_flat[b*8 +: 8] <= wr_data[15:8];
            end
        end
    end

endmodule

// File: rtl/cfg_router.sv
module cfg_router
    import cfg_router_pkg::*;
#(
    parameter int                          NUM_SLOTS   = 6,
    parameter int                          NUM_BRIDGES = 2,
    parameter logic [7:0]                  LOCAL_BUS   = 8'd0,
    parameter logic [NUM_SLOTS*8-1:0]      SLOT_DEVFN  = {8'h00, 8'h09, 8'h00, 8'h10, 8'h08, 8'h00},
    parameter logic [NUM_SLOTS*4-1:0]      SLOT_SEG    = {4'd2, 4'd1, 4'd1, 4'd0, 4'd0, 4'd0},
    parameter logic [NUM_BRIDGES*4-1:0]    BRIDGE_SLOT = {4'd2, 4'd1}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [23:0]             req_addr,
    input  logic [2:0]              req_len,
    input  logic [31:0]             req_wdata,
    output logic                    rsp_valid,
    output logic [31:0]             rsp_rdata,
    output logic [NUM_SLOTS-1:0]    slot_sel,
    output logic                    slot_write,
    output logic [7:0]              slot_offset,
    output logic [2:0]              slot_len,
    output logic [31:0]             slot_wdata,
    input  logic [NUM_SLOTS*32-1:0] slot_rdata,
    input  logic [NUM_SLOTS-1:0]    slot_present
);

    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int SEG_W = $clog2(NUM_BRIDGES + 1);

    rt_state_t                state_q, state_d;
    logic                     bus_claimed;
    logic [SEG_W-1:0]         bus_seg;
    logic                     route_hit;
    logic [IDX_W-1:0]         route_idx;
    logic [NUM_BRIDGES*8-1:0] sec_flat;

    logic [IDX_W-1:0]         idx_q;
    logic                     wr_q;
    logic [7:0]               off_q;
    logic [2:0]               len_q;
    logic [31:0]              wdata_q;

    cfg_bus_decode #(
        .NUM_BRIDGES (NUM_BRIDGES),
        .SEG_W       (SEG_W),
        .LOCAL_BUS   (LOCAL_BUS)
    ) u_bus (
        .bus_num  (req_addr[23:16]),
        .sec_flat (sec_flat),
        .claimed  (bus_claimed),
        .seg      (bus_seg)
    );

    cfg_slot_match #(
        .NUM_SLOTS  (NUM_SLOTS),
        .SEG_W      (SEG_W),
        .IDX_W      (IDX_W),
        .SLOT_DEVFN (SLOT_DEVFN),
        .SLOT_SEG   (SLOT_SEG)
    ) u_match (
        .claimed (bus_claimed),
        .seg     (bus_seg),
        .devfn   (req_addr[15:8]),
        .present (slot_present),
        .hit     (route_hit),
        .idx     (route_idx)
    );

    cfg_bridge_regs #(
        .NUM_BRIDGES (NUM_BRIDGES),
        .IDX_W       (IDX_W),
        .BRIDGE_SLOT (BRIDGE_SLOT)
    ) u_bregs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (req_valid && req_write && route_hit),
        .wr_idx    (route_idx),
        .wr_offset (req_addr[7:0]),
        .wr_len    (req_len),
        .wr_data   (req_wdata[15:0]),
        .sec_flat  (sec_flat)
    );

    // transitions: T_NONE, T_ROUTE, T_REJECT
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            state_d = route_hit ? ST_HIT : ST_MISS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            wr_q    <= 1'b0;
            off_q   <= 8'd0;
            len_q   <= 3'd0;
            wdata_q <= 32'd0;
        end else if (req_valid) begin
            idx_q   <= route_idx;
            wr_q    <= req_write;
            off_q   <= req_addr[7:0];
            len_q   <= req_len;
            wdata_q <= req_wdata;
        end
    end

    always_comb begin
        rsp_valid   = 1'b0;
        rsp_rdata   = 32'd0;
        slot_sel    = '0;
        slot_write  = 1'b0;
        slot_offset = 8'd0;
        slot_len    = 3'd0;
        slot_wdata  = 32'd0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_HIT: begin
                rsp_valid   = 1'b1;
                slot_sel    = NUM_SLOTS'(1) << idx_q;
                slot_write  = wr_q;
                slot_offset = off_q;
                slot_len    = len_q;
                slot_wdata  = wdata_q;
                rsp_rdata   = wr_q ? 32'd0 : slot_rdata[idx_q*32 +: 32];
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
                rsp_rdata = wr_q ? 32'd0 : miss_fill(len_q);
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/cfg_router_chk.sv
module cfg_router_chk
    import cfg_router_pkg::*;
#(
    parameter int NUM_SLOTS   = 6,
    parameter int NUM_BRIDGES = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_write,
    input logic [23:0]              req_addr,
    input logic [2:0]               req_len,
    input logic                     rsp_valid,
    input logic [31:0]              rsp_rdata,
    input logic [NUM_SLOTS-1:0]     slot_sel,
    input logic [7:0]               slot_offset,
    input logic [NUM_BRIDGES*8-1:0] sec_flat
);

    // R3
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R12
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_sel));

    // R12
    sel_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_sel != '0) |-> rsp_valid);

    // R5
    miss_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && slot_sel == '0 && !$past(req_write)) |->
            (rsp_rdata == miss_fill($past(req_len))));

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_sel != '0) |-> (slot_offset == $past(req_addr[7:0])));

    // R6
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid && req_write) |-> $stable(sec_flat));

endmodule

bind cfg_router cfg_router_chk #(
    .NUM_SLOTS   (NUM_SLOTS),
    .NUM_BRIDGES (NUM_BRIDGES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .slot_sel    (slot_sel),
    .slot_offset (slot_offset),
    .sec_flat    (sec_flat)
);

// File: tb/cfg_router_tb.sv
module cfg_router_tb;

    localparam int NS = 6;
    localparam int NB = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_write = 1'b0;
    logic [23:0]    req_addr = '0;
    logic [2:0]     req_len = '0;
    logic [31:0]    req_wdata = '0;
    logic           rsp_valid;
    logic [31:0]    rsp_rdata;
    logic [NS-1:0]  slot_sel;
    logic           slot_write;
    logic [7:0]     slot_offset;
    logic [2:0]     slot_len;
    logic [31:0]    slot_wdata;
    logic [NS*32-1:0] slot_rdata;
    logic [NS-1:0]  slot_present = '1;

    int checks = 0;
    int errors = 0;

    // reference model state
    int dev_devfn [NS] = '{8'h00, 8'h08, 8'h10, 8'h00, 8'h09, 8'h00};
    int dev_seg   [NS] = '{0, 0, 0, 1, 1, 2};
    int hdr_slot  [NB] = '{1, 2};
    int sec       [NB] = '{0, 0};

    bit          exp_v = 0;
    int          exp_idx = -1;
    bit          exp_w = 0;
    logic [31:0] exp_rdata = '0;
    logic [7:0]  exp_off = '0;
    logic [2:0]  exp_len = '0;
    logic [31:0] exp_wd = '0;
    string       exp_tag = "R12";

    always #5 clk = ~clk;

    cfg_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .slot_sel(slot_sel),
        .slot_write(slot_write), .slot_offset(slot_offset), .slot_len(slot_len),
        .slot_wdata(slot_wdata), .slot_rdata(slot_rdata), .slot_present(slot_present)
    );

    initial begin
        for (int i = 0; i < NS; i++) slot_rdata[i*32 +: 32] = 32'h5A00_0000 | (32'(i) << 4) | 32'h3;
    end

    function automatic logic [31:0] fill(input logic [2:0] l);
        if (l == 3'd1) return 32'hFF;
        if (l == 3'd2) return 32'hFFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic int route(input logic [23:0] a);
        int s = -1;
        int bus = int'(a[23:16]);
        if (bus == 0) s = 0;
        else for (int b = 0; b < NB; b++)
            if (s < 0 && sec[b] != 0 && sec[b] == bus) s = b + 1;
        if (s < 0) return -1;
        for (int i = 0; i < NS; i++)
            if (slot_present[i] && dev_seg[i] == s && dev_devfn[i] == int'(a[15:8])) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [NS-1:0] es;
        es = (exp_v && exp_idx >= 0) ? (NS'(1) << exp_idx) : '0;
        chk(rsp_valid == exp_v, exp_tag, "rsp_valid", 32'(rsp_valid), 32'(exp_v));
        chk(slot_sel == es, exp_tag, "slot_sel", 32'(slot_sel), 32'(es));
        chk(rsp_rdata == (exp_v ? exp_rdata : 32'd0), exp_tag, "rsp_rdata", rsp_rdata,
            exp_v ? exp_rdata : 32'd0);
        if (es != '0) begin
            chk(slot_write == exp_w, exp_tag, "slot_write", 32'(slot_write), 32'(exp_w));
            chk(slot_offset == exp_off, exp_tag, "slot_offset", 32'(slot_offset), 32'(exp_off));
            chk(slot_len == exp_len, exp_tag, "slot_len", 32'(slot_len), 32'(exp_len));
            if (exp_w) chk(slot_wdata == exp_wd, exp_tag, "slot_wdata", slot_wdata, exp_wd);
        end
    endtask

    // one clock: compare the previous cycle's response, then drive a new request
    task automatic cyc(input bit v, input bit w, input logic [23:0] a,
                       input logic [2:0] l, input logic [31:0] d, input string tag);
        @(negedge clk);
        compare();
        exp_v   = v;
        exp_tag = tag;
        exp_idx = -1;
        if (v) begin
            exp_idx   = route(a);
            exp_w     = w;
            exp_off   = a[7:0];
            exp_len   = l;
            exp_wd    = d;
            exp_rdata = w ? 32'd0 : (exp_idx >= 0 ? slot_rdata[exp_idx*32 +: 32] : fill(l));
            if (w && exp_idx >= 0)
                for (int b = 0; b < NB; b++)
                    if (exp_idx == hdr_slot[b]) begin
                        if (a[7:0] == 8'h19) sec[b] = int'(d[7:0]);
                        else if (a[7:0] == 8'h18 && l > 3'd1) sec[b] = int'(d[15:8]);
                    end
        end
        req_valid = v;
        req_write = w;
        req_addr  = a;
        req_len   = l;
        req_wdata = d;
    endtask

    task automatic rd(input logic [23:0] a, input logic [2:0] l, input string tag);
        cyc(1'b1, 1'b0, a, l, 32'd0, tag);
    endtask

    task automatic wr(input logic [23:0] a, input logic [2:0] l, input logic [31:0] d,
                      input string tag);
        cyc(1'b1, 1'b1, a, l, d, tag);
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 1'b0, 24'd0, 3'd0, 32'd0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // reset state (R9 / R12): no response while held in reset
        repeat (3) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R12", "reset rsp_valid", 32'(rsp_valid), 0);
            chk(slot_sel == '0, "R12", "reset slot_sel", 32'(slot_sel), 0);
        end
        rst_n = 1'b1;
        idle("R12");

        // R1 / R4: local reads
        rd(24'h00_00_3C, 3'd4, "R4");
        rd(24'h00_08_04, 3'd2, "R1");
        // R5: miss reads at every length
        rd(24'h00_18_00, 3'd1, "R5");
        rd(24'h00_18_00, 3'd2, "R5");
        rd(24'h00_18_00, 3'd4, "R5");
        // R9: unnumbered bridges claim nothing
        rd(24'h01_00_00, 3'd4, "R9");
        rd(24'h00_00_00, 3'd4, "R9");
        idle("R3");

        // R7: number bridge 0 through offset 0x19
        wr(24'h00_08_19, 3'd1, 32'h0000_0005, "R7");
        rd(24'h05_00_10, 3'd4, "R7");
        rd(24'h05_09_20, 3'd2, "R2");
        rd(24'h05_08_00, 3'd4, "R2");
        // R8: number bridge 1 through offset 0x18, length 4
        wr(24'h00_10_18, 3'd4, 32'hAB12_0700, "R8");
        rd(24'h07_00_00, 3'd4, "R8");
        // R8: length-1 write at 0x18 ignored
        wr(24'h00_08_18, 3'd1, 32'h0000_0909, "R8");
        rd(24'h09_00_00, 3'd4, "R8");
        rd(24'h05_00_00, 3'd4, "R8");
        // R7: offset 0x19 on a non-bridge slot changes nothing
        wr(24'h00_00_19, 3'd1, 32'h0000_000C, "R7");
        rd(24'h0C_00_00, 3'd1, "R7");
        rd(24'h05_00_00, 3'd4, "R7");
        // R6: write to unclaimed bus dropped
        wr(24'h03_08_19, 3'd1, 32'h0000_0021, "R6");
        wr(24'h05_18_19, 3'd1, 32'h0000_0022, "R6");
        rd(24'h21_00_00, 3'd4, "R6");
        rd(24'h05_00_00, 3'd4, "R6");
        // R3 / R12: routed write to an ordinary slot, back to back
        wr(24'h07_00_44, 3'd2, 32'hCAFE_F00D, "R3");
        wr(24'h05_09_40, 3'd4, 32'h1234_5678, "R12");
        rd(24'h00_00_08, 3'd1, "R3");
        idle("R3");

        // R10: both bridges on bus 5 -> lowest bridge wins
        wr(24'h00_10_19, 3'd1, 32'h0000_0005, "R10");
        rd(24'h05_00_00, 3'd4, "R10");
        rd(24'h07_00_00, 3'd4, "R10");
        // R10: restore bridge 1, local bus still wins over anything
        wr(24'h00_10_18, 3'd2, 32'h0000_0700, "R10");
        rd(24'h07_00_00, 3'd4, "R10");
        idle("R10");

        // R11: absent slot
        slot_present[4] = 1'b0;
        rd(24'h05_09_00, 3'd2, "R11");
        rd(24'h05_00_00, 3'd4, "R11");
        idle("R11");
        slot_present[4] = 1'b1;
        rd(24'h05_09_00, 3'd4, "R11");
        idle("R12");
        idle("R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule